// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs single-byte read and write cycles on an 8-bit external memory bus. Three devices share the bus: an SRAM, a flash device and a small peripheral. Two masters place requests with the block: a host side and an embedded-core side. Each request is a one-clock pulse. It carries a 17-bit address, a 2-bit target code, a write flag and write data. The block holds each request in a per-master slot and grants the bus with a fixed priority. It then decodes the target and drives the address, the bidirectional data bus and the active-low chip enables and strobes through four phases. At the end it returns read data together with a one-clock done pulse to the master that made the request.

A write is sequenced so that the address and chip enable settle one clock before the write enable falls. The data stays driven for one clock after the write enable rises. The peripheral is reachable only from the embedded core. A host request aimed at it, or any request with the unused target code, ends in a one-clock error pulse and the bus does not move. An asynchronous active-low reset forces every bus output inactive at once and drops both pending requests and any cycle in progress.

Top module: `membus_seq`

## Requirements
- R1: While `rst_n` is low, all three chip enables, `oe_n` and `we_n` are high, the block does not drive `mem_data`, and every done and error output is low.
- R2: Target code 0 selects the SRAM (`sram_ce_n`), 1 selects the flash (`flash_ce_n`) and 2 selects the peripheral (`per_ce_n`). At most one chip enable is low at any time. `mem_addr` carries the request address, except for the peripheral, where every bit above bit 3 is forced to zero.
- R3: On a write, `we_n` falls only in a clock after the chip enable has been low for a full clock, and `mem_addr` does not change at that edge. The block drives the write data on `mem_data` for as long as `we_n` is low. The data is unchanged at the rising edge of `we_n` and is still driven for one further clock.
- R4: On a read, `oe_n` is low during the strobe phase and `we_n` stays high. The block never drives `mem_data` while `oe_n` is low. The byte present on the bus at the last strobe clock appears on `rd_data` with the done pulse.
- R5: With `wait_states` = W (0 to 7), the strobe stays low for W+1 clocks. The done pulse becomes visible W+4 clock edges after the edge that samples the request.
- R6: Done is a single-clock pulse, given only to the master that owns the cycle.
- R7: A host request with target code 2 asserts its error output one clock edge after the request is sampled. No done follows, and no chip enable or strobe toggles.
- R8: A request from either master with target code 3 gets the same error response as R7.
- R9: When both masters request at the same edge, the core cycle runs first. The host request waits and runs after the bus returns to idle, with its done 2W+8 edges after the shared request edge.
- R10: A reset asserted in the middle of a cycle returns the bus outputs to inactive at once. It discards the cycle and any pending request, so no done or error follows and the abandoned write leaves no mark in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_states | input | 3 | Extra strobe clocks per cycle |
| host_req | input | 1 | Host request pulse |
| host_addr | input | 17 | Host address |
| host_tgt | input | 2 | Host target code |
| host_wr | input | 1 | Host write flag |
| host_wdata | input | 8 | Host write data |
| host_done | output | 1 | Host cycle complete |
| host_err | output | 1 | Host request rejected |
| core_req | input | 1 | Core request pulse |
| core_addr | input | 17 | Core address |
| core_tgt | input | 2 | Core target code |
| core_wr | input | 1 | Core write flag |
| core_wdata | input | 8 | Core write data |
| core_done | output | 1 | Core cycle complete |
| core_err | output | 1 | Core request rejected |
| rd_data | output | 8 | Read data, valid with done |
| mem_addr | output | 17 | External address bus |
| mem_data | inout | 8 | External data bus, bit 7 most significant |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| per_ce_n | output | 1 | Peripheral chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
A granted cycle has fixed latency. From the edge that samples a request pulse, done is due W+4 edges later, and a rejection raises error one edge later. A host request that loses to the core finishes 2W+8 edges after the shared edge. For every operation the bench counts rising edges from the sampling edge and reads done, error and `rd_data` at the falling edge that follows. It compares that count with the value due for the operation, then checks on the next falling edge that done has dropped again. A falling-edge monitor counts the strobe clocks and records the chip enables and the address seen during the cycle, so the length of the strobe and the decode are checked for each operation.

// File: rtl/membus_pkg.sv
package membus_pkg;

  // target codes carried with each request
  typedef enum logic [1:0] {
    TGT_SRAM   = 2'd0,
    TGT_FLASH  = 2'd1,
    TGT_PERIPH = 2'd2,
    TGT_NONE   = 2'd3
  } tgt_e;

  // bus cycle phases
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // device select bit positions
  localparam int DEV_SRAM  = 0;
  localparam int DEV_FLASH = 1;
  localparam int DEV_PER   = 2;
  localparam int N_DEV     = 3;

  // master indices
  localparam int M_HOST = 0;
  localparam int M_CORE = 1;
  localparam int N_MST  = 2;

endpackage

// File: rtl/membus_slot.sv
// Holds one master's request until the sequencer takes it.
module membus_slot #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        tgt,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              pend_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        tgt_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] wdata_q
);

  logic pend_d;
  logic load_en;

  always_comb begin
    load_en = req;
    pend_d  = (pend_q & ~take) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      tgt_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (load_en) begin
      addr_q  <= addr;
      tgt_q   <= tgt;
      wr_q    <= wr;
      wdata_q <= wdata;
    end
  end

endmodule

// File: rtl/membus_decode.sv
// Target decode and legality check for the granted request.
module membus_decode
  import membus_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int PER_WIN_W = 4
) (
  input  logic              from_core,
  input  logic [1:0]        tgt,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [N_DEV-1:0]  dev_sel,
  output logic              legal,
  output logic [ADDR_W-1:0] addr_out
);

  localparam logic [ADDR_W-1:0] PER_MASK = ADDR_W'((1 << PER_WIN_W) - 1);

  always_comb begin
    dev_sel  = '0;
    legal    = 1'b1;
    addr_out = addr_in;
    unique case (tgt)
      TGT_SRAM:  dev_sel[DEV_SRAM]  = 1'b1;
      TGT_FLASH: dev_sel[DEV_FLASH] = 1'b1;
      TGT_PERIPH: begin
        if (from_core) begin
          dev_sel[DEV_PER] = 1'b1;
          addr_out         = addr_in & PER_MASK;
        end else begin
          legal = 1'b0;
        end
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/membus_phase.sv
// Four-phase bus cycle sequencer with registered bus outputs.
module membus_phase
  import membus_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int WS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reject,
  input  logic              owner_in,
  input  logic [N_DEV-1:0]  dev_sel,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [WS_W-1:0]   ws,
  input  logic [DATA_W-1:0] bus_in,
  output logic              idle,
  output logic [ADDR_W-1:0] addr_q,
  output logic [N_DEV-1:0]  ce_q,
  output logic              oe_q,
  output logic              we_q,
  output logic              drv_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic [N_MST-1:0]  done_q,
  output logic [N_MST-1:0]  err_q,
  output logic              owner_q
);

  phase_e            state_q, state_d;
  logic [WS_W-1:0]   cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_d;
  logic [N_DEV-1:0]  ce_d;
  logic              oe_d, we_d, drv_d, owner_d;
  logic [DATA_W-1:0] wdata_d, rdata_d;
  logic [N_MST-1:0]  done_d, err_d;
  logic [N_MST-1:0]  owner_vec, in_vec;

  always_comb begin
    owner_vec         = '0;
    owner_vec[M_CORE] = owner_q;
    owner_vec[M_HOST] = ~owner_q;
    in_vec            = '0;
    in_vec[M_CORE]    = owner_in;
    in_vec[M_HOST]    = ~owner_in;
  end

  assign idle = (state_q == PH_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    ce_d    = ce_q;
    oe_d    = oe_q;
    we_d    = we_q;
    drv_d   = drv_q;
    owner_d = owner_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    done_d  = '0;
    err_d   = '0;
    unique case (state_q)
      PH_IDLE: begin
        if (start) begin
          state_d = PH_SETUP;
          addr_d  = addr_in;
          ce_d    = dev_sel;
          wr_d    = wr_in;
          wdata_d = wdata_in;
          owner_d = owner_in;
          drv_d   = wr_in;
        end else if (reject) begin
          err_d = in_vec;
        end
      end
      PH_SETUP: begin
        state_d = PH_STROBE;
        cnt_d   = ws;
        we_d    = wr_q;
        oe_d    = ~wr_q;
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          state_d = PH_HOLD;
          we_d    = 1'b0;
          oe_d    = 1'b0;
          if (!wr_q) rdata_d = bus_in;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        state_d = PH_IDLE;
        ce_d    = '0;
        drv_d   = 1'b0;
        done_d  = owner_vec;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      ce_q    <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      drv_q   <= 1'b0;
      owner_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= '0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      ce_q    <= ce_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      drv_q   <= drv_d;
      owner_q <= owner_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

endmodule

// File: rtl/membus_seq.sv
// Top: request slots, fixed-priority grant, decode and phase sequencer.
module membus_seq
  import membus_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int WS_W      = 3,
  parameter int PER_WIN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WS_W-1:0]   wait_states,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_tgt,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_done,
  output logic              host_err,
  input  logic              core_req,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [1:0]        core_tgt,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_done,
  output logic              core_err,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_data,
  output logic              sram_ce_n,
  output logic              flash_ce_n,
  output logic              per_ce_n,
  output logic              oe_n,
  output logic              we_n
);

  logic [N_MST-1:0]  in_req, in_wr, pend, p_wr, take;
  logic [ADDR_W-1:0] in_addr  [N_MST];
  logic [1:0]        in_tgt   [N_MST];
  logic [DATA_W-1:0] in_wdata [N_MST];
  logic [ADDR_W-1:0] p_addr   [N_MST];
  logic [1:0]        p_tgt    [N_MST];
  logic [DATA_W-1:0] p_wdata  [N_MST];

  always_comb begin
    in_req[M_HOST]   = host_req;
    in_addr[M_HOST]  = host_addr;
    in_tgt[M_HOST]   = host_tgt;
    in_wr[M_HOST]    = host_wr;
    in_wdata[M_HOST] = host_wdata;
    in_req[M_CORE]   = core_req;
    in_addr[M_CORE]  = core_addr;
    in_tgt[M_CORE]   = core_tgt;
    in_wr[M_CORE]    = core_wr;
    in_wdata[M_CORE] = core_wdata;
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_slot
    membus_slot #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (in_req[m]),
      .addr    (in_addr[m]),
      .tgt     (in_tgt[m]),
      .wr      (in_wr[m]),
      .wdata   (in_wdata[m]),
      .take    (take[m]),
      .pend_q  (pend[m]),
      .addr_q  (p_addr[m]),
      .tgt_q   (p_tgt[m]),
      .wr_q    (p_wr[m]),
      .wdata_q (p_wdata[m])
    );
  end

  // fixed priority: core ahead of host
  logic              idle, sel_core, legal;
  logic [ADDR_W-1:0] sel_addr, dec_addr;
  logic [1:0]        sel_tgt;
  logic              sel_wr;
  logic [DATA_W-1:0] sel_wdata;
  logic [N_DEV-1:0]  dev_sel;

  always_comb begin
    take[M_CORE] = idle & pend[M_CORE];
    take[M_HOST] = idle & pend[M_HOST] & ~pend[M_CORE];
    sel_core     = pend[M_CORE];
    sel_addr     = sel_core ? p_addr[M_CORE]  : p_addr[M_HOST];
    sel_tgt      = sel_core ? p_tgt[M_CORE]   : p_tgt[M_HOST];
    sel_wr       = sel_core ? p_wr[M_CORE]    : p_wr[M_HOST];
    sel_wdata    = sel_core ? p_wdata[M_CORE] : p_wdata[M_HOST];
  end

  membus_decode #(
    .ADDR_W    (ADDR_W),
    .PER_WIN_W (PER_WIN_W)
  ) u_dec (
    .from_core (sel_core),
    .tgt       (sel_tgt),
    .addr_in   (sel_addr),
    .dev_sel   (dev_sel),
    .legal     (legal),
    .addr_out  (dec_addr)
  );

  logic              granted;
  logic [N_DEV-1:0]  ce_q;
  logic              oe_q, we_q, bus_drv, owner_core;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [N_MST-1:0]  done_q, err_q;

  assign granted = |take;

  membus_phase #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WS_W   (WS_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (granted & legal),
    .reject   (granted & ~legal),
    .owner_in (sel_core),
    .dev_sel  (dev_sel),
    .addr_in  (dec_addr),
    .wr_in    (sel_wr),
    .wdata_in (sel_wdata),
    .ws       (wait_states),
    .bus_in   (mem_data),
    .idle     (idle),
    .addr_q   (mem_addr),
    .ce_q     (ce_q),
    .oe_q     (oe_q),
    .we_q     (we_q),
    .drv_q    (bus_drv),
    .wdata_q  (wdata_q),
    .rdata_q  (rdata_q),
    .done_q   (done_q),
    .err_q    (err_q),
    .owner_q  (owner_core)
  );

  assign mem_data   = bus_drv ? wdata_q : {DATA_W{1'bz}};
  assign sram_ce_n  = ~ce_q[DEV_SRAM];
  assign flash_ce_n = ~ce_q[DEV_FLASH];
  assign per_ce_n   = ~ce_q[DEV_PER];
  assign oe_n       = ~oe_q;
  assign we_n       = ~we_q;
  assign rd_data    = rdata_q;
  assign host_done  = done_q[M_HOST];
  assign core_done  = done_q[M_CORE];
  assign host_err   = err_q[M_HOST];
  assign core_err   = err_q[M_CORE];

endmodule

// File: rtl/membus_seq_chk.sv
module membus_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              sram_ce_n,
  input logic              flash_ce_n,
  input logic              per_ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              drv_en,
  input logic              owner_core,
  input logic              host_done,
  input logic              core_done,
  input logic              host_err,
  input logic              core_err
);

  logic any_ce_n;
  assign any_ce_n = sram_ce_n & flash_ce_n & per_ce_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (any_ce_n && oe_n && we_n && !drv_en &&
                                    !host_done && !core_done && !host_err && !core_err);
    end
  end

  assert_one_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~sram_ce_n, ~flash_ce_n, ~per_ce_n}));

  assert_we_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (!$past(any_ce_n) && $stable(mem_addr)));

  assert_we_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> drv_en);

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (drv_en && $stable(mem_data)));

  assert_read_nodrive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!drv_en && we_n));

  assert_host_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  assert_core_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);

  assert_per_core_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !per_ce_n |-> owner_core);

endmodule

bind membus_seq membus_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data),
  .sram_ce_n  (sram_ce_n),
  .flash_ce_n (flash_ce_n),
  .per_ce_n   (per_ce_n),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .drv_en     (bus_drv),
  .owner_core (owner_core),
  .host_done  (host_done),
  .core_done  (core_done),
  .host_err   (host_err),
  .core_err   (core_err)
);

// File: tb/test_membus_seq.sv
module test_membus_seq;

  logic        clk;
  logic        rst_n;
  logic [2:0]  wait_states;
  logic        host_req, host_wr, host_done, host_err;
  logic [16:0] host_addr;
  logic [1:0]  host_tgt;
  logic [7:0]  host_wdata;
  logic        core_req, core_wr, core_done, core_err;
  logic [16:0] core_addr;
  logic [1:0]  core_tgt;
  logic [7:0]  core_wdata;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  wire  [7:0]  mem_bus;
  logic        sram_ce_n, flash_ce_n, per_ce_n, oe_n, we_n;

  int n_checks = 0;
  int n_errors = 0;

  membus_seq i_membus_seq (
    .clk(clk), .rst_n(rst_n), .wait_states(wait_states),
    .host_req(host_req), .host_addr(host_addr), .host_tgt(host_tgt),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_done(host_done), .host_err(host_err),
    .core_req(core_req), .core_addr(core_addr), .core_tgt(core_tgt),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_done(core_done), .core_err(core_err),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_data(mem_bus),
    .sram_ce_n(sram_ce_n), .flash_ce_n(flash_ce_n), .per_ce_n(per_ce_n),
    .oe_n(oe_n), .we_n(we_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // device models and independent shadow copies
  logic [7:0] dev_sram [32];
  logic [7:0] dev_flash[32];
  logic [7:0] dev_per  [16];
  logic [7:0] sh_sram  [32];
  logic [7:0] sh_flash [32];
  logic [7:0] sh_per   [16];
  logic [7:0] dev_out;

  always_comb begin
    if (!sram_ce_n)       dev_out = dev_sram[mem_addr[4:0]];
    else if (!flash_ce_n) dev_out = dev_flash[mem_addr[4:0]];
    else if (!per_ce_n)   dev_out = dev_per[mem_addr[3:0]];
    else                  dev_out = 8'hEE;
  end
  assign mem_bus = !oe_n ? dev_out : 8'bzzzzzzzz;

  always @(posedge we_n) begin
    if (!sram_ce_n)  dev_sram[mem_addr[4:0]]  = mem_bus;
    if (!flash_ce_n) dev_flash[mem_addr[4:0]] = mem_bus;
    if (!per_ce_n)   dev_per[mem_addr[3:0]]   = mem_bus;
  end

  // bus monitor
  int          strobe_n;
  bit [2:0]    saw_ce;
  bit          saw_we, saw_oe;
  logic [16:0] seen_addr;

  always @(negedge clk) begin
    if (!sram_ce_n)  saw_ce[0] = 1'b1;
    if (!flash_ce_n) saw_ce[1] = 1'b1;
    if (!per_ce_n)   saw_ce[2] = 1'b1;
    if (!(sram_ce_n && flash_ce_n && per_ce_n)) seen_addr = mem_addr;
    if (!we_n) saw_we = 1'b1;
    if (!oe_n) saw_oe = 1'b1;
    if (!we_n || !oe_n) strobe_n++;
  end

  task automatic clear_mon();
    strobe_n = 0; saw_ce = '0; saw_we = 1'b0; saw_oe = 1'b0; seen_addr = '0;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        core;
    logic [1:0]  tgt;
    logic        wr;
    logic [16:0] addr;
    logic [7:0]  wdata;
    logic [2:0]  ws;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b1, 17'h00005, 8'hA5, 3'd0},
    '{1'b1, 2'd0, 1'b0, 17'h00005, 8'h00, 3'd0},
    '{1'b0, 2'd1, 1'b1, 17'h10009, 8'h3C, 3'd3},
    '{1'b0, 2'd1, 1'b0, 17'h10009, 8'h00, 3'd7},
    '{1'b1, 2'd2, 1'b1, 17'h1FFF2, 8'h5A, 3'd1},
    '{1'b1, 2'd2, 1'b0, 17'h00002, 8'h00, 3'd2},
    '{1'b0, 2'd2, 1'b0, 17'h00002, 8'h00, 3'd0},
    '{1'b0, 2'd2, 1'b1, 17'h00002, 8'h99, 3'd4},
    '{1'b1, 2'd2, 1'b0, 17'h00002, 8'h00, 3'd0},
    '{1'b1, 2'd3, 1'b1, 17'h00004, 8'h11, 3'd2},
    '{1'b0, 2'd0, 1'b0, 17'h00007, 8'h00, 3'd5},
    '{1'b0, 2'd0, 1'b1, 17'h0001F, 8'hFF, 3'd7},
    '{1'b1, 2'd0, 1'b0, 17'h0001F, 8'h00, 3'd4}
  };

  task automatic drive_req(input bit core, input logic [1:0] tgt, input bit wr,
                           input logic [16:0] a, input logic [7:0] d);
    if (core) begin
      core_req = 1'b1; core_tgt = tgt; core_wr = wr; core_addr = a; core_wdata = d;
    end else begin
      host_req = 1'b1; host_tgt = tgt; host_wr = wr; host_addr = a; host_wdata = d;
    end
  endtask

  function automatic logic [7:0] shadow_rd(input logic [1:0] tgt, input logic [16:0] a);
    case (tgt)
      2'd0:    return sh_sram[a[4:0]];
      2'd1:    return sh_flash[a[4:0]];
      default: return sh_per[a[3:0]];
    endcase
  endfunction

  // one operation; tag selects the requirement the vector exercises
  task automatic run_one(input vec_t v);
    bit          exp_err, got, got_err, other;
    int          n, exp_n;
    logic [2:0]  exp_ce;
    logic [16:0] exp_addr;
    logic [7:0]  exp_rd;
    string       etag;
    exp_err  = (v.tgt == 2'd3) || (v.tgt == 2'd2 && !v.core);
    etag     = (v.tgt == 2'd3) ? "R8" : "R7";
    exp_ce   = (v.tgt == 2'd0) ? 3'b001 : (v.tgt == 2'd1) ? 3'b010 : 3'b100;
    exp_addr = (v.tgt == 2'd2) ? (v.addr & 17'h0000F) : v.addr;
    exp_rd   = shadow_rd(v.tgt, v.addr);
    exp_n    = exp_err ? 2 : int'(v.ws) + 5;
    @(negedge clk);
    wait_states = v.ws;
    clear_mon();
    drive_req(v.core, v.tgt, v.wr, v.addr, v.wdata);
    n = 0; got = 1'b0; got_err = 1'b0; other = 1'b0;
    while (!got && n < 60) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) begin host_req = 1'b0; core_req = 1'b0; end
      if (v.core) begin
        if (core_done || core_err) begin got = 1'b1; got_err = core_err; end
        if (host_done || host_err) other = 1'b1;
      end else begin
        if (host_done || host_err) begin got = 1'b1; got_err = host_err; end
        if (core_done || core_err) other = 1'b1;
      end
    end
    check(n == exp_n, exp_err ? etag : "R5", "completion latency", n, exp_n);
    check(got_err == exp_err, exp_err ? etag : "R6", "error flag", got_err, exp_err);
    check(!other, "R6", "other master response", other, 0);
    if (exp_err) begin
      check(saw_ce == 3'b000 && !saw_we && !saw_oe, etag, "bus activity on reject",
            {saw_ce, saw_we, saw_oe}, 0);
    end else begin
      check(saw_ce == exp_ce, "R2", "chip enable selected", saw_ce, exp_ce);
      check(seen_addr == exp_addr, "R2", "address on bus", seen_addr, exp_addr);
      check(strobe_n == int'(v.ws) + 1, "R5", "strobe length", strobe_n, int'(v.ws) + 1);
      if (v.wr) begin
        check(saw_we && !saw_oe, "R3", "write strobes", {saw_we, saw_oe}, 2'b10);
        case (v.tgt)
          2'd0:    sh_sram[v.addr[4:0]]  = v.wdata;
          2'd1:    sh_flash[v.addr[4:0]] = v.wdata;
          default: sh_per[v.addr[3:0]]   = v.wdata;
        endcase
      end else begin
        check(saw_oe && !saw_we, "R4", "read strobes", {saw_we, saw_oe}, 2'b01);
        check(rd_data == exp_rd, "R4", "read data", rd_data, exp_rd);
      end
    end
    @(negedge clk);
    check(!host_done && !core_done && !host_err && !core_err, "R6", "single-cycle response",
          {host_done, core_done, host_err, core_err}, 0);
  endtask

  // watchdog
  initial begin
    #(20 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int n, core_n, host_n;
    bit any_resp;
    for (int i = 0; i < 32; i++) begin
      dev_sram[i] = 8'(i * 7 + 1);  sh_sram[i]  = 8'(i * 7 + 1);
      dev_flash[i] = 8'(i * 5 + 3); sh_flash[i] = 8'(i * 5 + 3);
    end
    for (int i = 0; i < 16; i++) begin
      dev_per[i] = 8'(i * 3 + 2); sh_per[i] = 8'(i * 3 + 2);
    end
    rst_n = 1'b0; wait_states = '0;
    host_req = 1'b0; host_addr = '0; host_tgt = '0; host_wr = 1'b0; host_wdata = '0;
    core_req = 1'b0; core_addr = '0; core_tgt = '0; core_wr = 1'b0; core_wdata = '0;
    clear_mon();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sram_ce_n && flash_ce_n && per_ce_n, "R1", "chip enables in reset",
          {sram_ce_n, flash_ce_n, per_ce_n}, 3'b111);
    check(oe_n && we_n, "R1", "strobes in reset", {oe_n, we_n}, 2'b11);
    check(!host_done && !core_done && !host_err && !core_err, "R1", "responses in reset",
          {host_done, core_done, host_err, core_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NV; k++) run_one(VECS[k]);

    // R9: simultaneous requests, core first then host reading what core wrote
    @(negedge clk);
    wait_states = 3'd2;
    drive_req(1'b1, 2'd0, 1'b1, 17'h00009, 8'h11);
    drive_req(1'b0, 2'd0, 1'b0, 17'h00009, 8'h00);
    n = 0; core_n = 0; host_n = 0;
    while (host_n == 0 && n < 80) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) begin host_req = 1'b0; core_req = 1'b0; end
      if (core_done) core_n = n;
      if (host_done) begin
        host_n = n;
        check(rd_data == 8'h11, "R9", "host read after core write", rd_data, 8'h11);
      end
    end
    sh_sram[9] = 8'h11;
    check(core_n == 7, "R9", "core done edge", core_n, 7);
    check(host_n == 13, "R9", "host done edge", host_n, 13);

    // R10: reset during setup abandons the write and the pending host request
    @(negedge clk);
    wait_states = 3'd7;
    drive_req(1'b1, 2'd0, 1'b1, 17'h00003, 8'h77);
    drive_req(1'b0, 2'd1, 1'b0, 17'h00004, 8'h00);
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0; core_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!sram_ce_n, "R10", "cycle started before reset", sram_ce_n, 0);
    rst_n = 1'b0;
    #1;
    check(sram_ce_n && flash_ce_n && per_ce_n && oe_n && we_n, "R10",
          "outputs inactive at reset", {sram_ce_n, flash_ce_n, per_ce_n, oe_n, we_n}, 5'h1F);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    any_resp = 1'b0;
    clear_mon();
    repeat (30) begin
      @(negedge clk);
      if (host_done || core_done || host_err || core_err) any_resp = 1'b1;
    end
    check(!any_resp, "R10", "no response after abandoned cycle", any_resp, 0);
    check(saw_ce == 3'b000, "R10", "no bus cycle after reset", saw_ce, 0);
    run_one('{1'b1, 2'd0, 1'b0, 17'h00003, 8'h00, 3'd1});

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule